// File: doc/BRIEF.md
# Keyboard Matrix Group Scanner

This block sits behind a processor-visible keyboard port that faces an 8x8 passive key matrix. Software writes a group-select byte. A 0 in bit g turns scanning of group g on. It then strobes a read and receives one byte of active-low key bits, gathered from every group that is being scanned at that moment.

Two effects of a real passive matrix are reproduced. First, turning a group on is instantaneous, but a group that is turned off keeps feeding its pressed keys into reads for a settling window. That window grows with the number of groups switched off in the same write. Second, pressed keys that sit on the same key bit in different groups short those groups together, so one selected group can pull further groups into a read, and chains of such shorts can pull in the whole matrix.

Top module: `kbd_group_scan`

## Requirements
- R1: After reset the stored select byte is 0xFF (no group scanned), no group is in its settling window, and `rd_data_o` is 0xFF.
- R2: Bit g of a written byte set to 0 enables group g. Key bit i of group g is `keys_i[g*8+i]` (1 = pressed). Read bit i is 0 when key i is pressed in any scanned group.
- R3: `rd_data_o` is loaded at the clock edge where `rd_i` is high, from the state that held before that edge. It holds its value on every other cycle.
- R4: With no key pressed, a read returns 0xFF whatever the select state.
- R5: The select byte is kept until the next write. Writing 0xFF is an ordinary write that only turns every group off.
- R6: A group turned on by a write is visible to a read whose edge is one cycle after the write edge.
- R7: A group turned off by a write still contributes to reads at edges 1..D cycles after the write edge, and no longer at D+1.
- R8: With k groups turned off in one write, D = DLY_ONE + ((DLY_ALL-DLY_ONE)*(k-1))/(NUM_GROUPS-1), using integer division. The defaults give 8 for k=1, 13 for k=2 and 48 for k=8.
- R9: Turning a group on clears its settling window. Turning it off again restarts the window from D. A write that leaves an already-off group off does not restart its window.
- R10: Any group with a pressed key on a bit that is pressed in a scanned group is scanned as well. This rule is applied transitively. Groups with no shared pressed bit are not added.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| keys_i | input | 64 | Pressed-key vector, index g*8+i |
| wr_i | input | 1 | Write strobe for the select byte |
| wr_data_i | input | 8 | Active-low group-select byte |
| rd_i | input | 1 | Read strobe |
| rd_data_o | output | 8 | Active-low key bits from the last read |

## Verification
The bench reads exactly at the last cycle of each settling window and at the cycle just after it, for one, two and eight groups turned off together. An off-by-one counter, or a window that ignores the group count, misses one of these two reads. It re-enables and re-disables a group partway through a window, and separately writes 0xFF twice in a row. A design that fails to restart the window, or that restarts it on a redundant write, reports the wrong byte. A three-group chain of shared key bits exposes a bridging pass that is only one level deep. An unrelated pressed key must stay out of the result, which catches bridging that is too wide.

// File: rtl/kbd_scan_pkg.sv
package kbd_scan_pkg;

   // Settling window for n_off groups switched off by one write: linear
   // between the single-group and whole-matrix values.
   function automatic int unsigned hold_cycles(input int unsigned n_off,
                                               input int unsigned n_grp,
                                               input int unsigned d_one,
                                               input int unsigned d_all);
      if (n_off <= 1 || n_grp <= 1) return d_one;
      return d_one + ((d_all - d_one) * (n_off - 1)) / (n_grp - 1);
   endfunction

endpackage

// File: rtl/kbd_hold_timer.sv
module kbd_hold_timer #(
   parameter int CW = 6
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          clr_i,
   input  logic          load_i,
   input  logic [CW-1:0] load_val_i,
   output logic          live_o
);
   logic [CW-1:0] cnt_q;

   always_ff @(posedge clk) begin
      if (!rst_n)          cnt_q <= '0;
      else if (clr_i)      cnt_q <= '0;
      else if (load_i)     cnt_q <= load_val_i;
      else if (cnt_q != 0) cnt_q <= cnt_q - 1'b1;
   end

   assign live_o = (cnt_q != '0);

   AST_HOLD_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      (live_o && !load_i && !clr_i) |=> (cnt_q == $past(cnt_q) - 1'b1)); // R7
   AST_HOLD_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
      clr_i |=> !live_o); // R9
   AST_HOLD_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
      (load_i && !clr_i && load_val_i != '0) |=> live_o); // R9
endmodule

// File: rtl/kbd_bridge_closure.sv
module kbd_bridge_closure #(
   parameter int NG = 8,
   parameter int NB = 8
) (
   input  logic [NG*NB-1:0] keys_i,
   input  logic [NG-1:0]    seed_i,
   output logic [NG-1:0]    scan_o,
   output logic [NB-1:0]    col_o
);
   logic [NG-1:0] act;
   logic [NB-1:0] hit;

   always_comb begin
      act = seed_i;
      hit = '0;
      for (int it = 0; it < NG; it++) begin
         hit = '0;
         for (int g = 0; g < NG; g++)
            if (act[g]) hit = hit | keys_i[g*NB +: NB];
         for (int g = 0; g < NG; g++)
            if (|(keys_i[g*NB +: NB] & hit)) act[g] = 1'b1;
      end
      hit = '0;
      for (int g = 0; g < NG; g++)
         if (act[g]) hit = hit | keys_i[g*NB +: NB];
   end

   assign scan_o = act;
   assign col_o  = hit;

   // The final set must be closed: no unscanned group shares a pressed bit.
   always_comb begin
      for (int g = 0; g < NG; g++)
         AST_CLOSED: assert (!(|(keys_i[g*NB +: NB] & col_o)) || scan_o[g]); // R10
   end
endmodule

// File: rtl/kbd_group_scan.sv
module kbd_group_scan #(
   parameter int NUM_GROUPS = 8,
   parameter int NUM_BITS   = 8,
   parameter int DLY_ONE    = 8,
   parameter int DLY_ALL    = 48
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic [NUM_GROUPS*NUM_BITS-1:0] keys_i,
   input  logic                       wr_i,
   input  logic [NUM_GROUPS-1:0]      wr_data_i,
   input  logic                       rd_i,
   output logic [NUM_BITS-1:0]        rd_data_o
);
   import kbd_scan_pkg::*;

   localparam int CW = $clog2(DLY_ALL + 1);

   generate
      if (DLY_ONE < 1 || DLY_ALL < DLY_ONE || NUM_GROUPS < 1 || NUM_BITS < 1) begin : g_bad_cfg
         $error("kbd_group_scan: invalid delay or size parameters");
      end
   endgenerate

   logic [NUM_GROUPS-1:0] mask_q;
   logic [NUM_GROUPS-1:0] going_off;
   logic [NUM_GROUPS-1:0] live;
   logic [NUM_GROUPS-1:0] seed;
   logic [NUM_GROUPS-1:0] scan;
   logic [NUM_BITS-1:0]   col;
   logic [CW-1:0]         load_val;

   always_ff @(posedge clk) begin
      if (!rst_n)    mask_q <= '1;
      else if (wr_i) mask_q <= wr_data_i;
   end

   assign going_off = wr_i ? (~mask_q & wr_data_i) : '0;
   assign load_val  = CW'(hold_cycles($countones(going_off), NUM_GROUPS, DLY_ONE, DLY_ALL));

   for (genvar g = 0; g < NUM_GROUPS; g++) begin : g_timer
      kbd_hold_timer #(.CW(CW)) u_hold (
         .clk       (clk),
         .rst_n     (rst_n),
         .clr_i     (wr_i & ~wr_data_i[g]),
         .load_i    (going_off[g]),
         .load_val_i(load_val),
         .live_o    (live[g])
      );
   end

   assign seed = ~mask_q | live;

   kbd_bridge_closure #(.NG(NUM_GROUPS), .NB(NUM_BITS)) u_bridge (
      .keys_i(keys_i),
      .seed_i(seed),
      .scan_o(scan),
      .col_o (col)
   );

   always_ff @(posedge clk) begin
      if (!rst_n)    rd_data_o <= '1;
      else if (rd_i) rd_data_o <= ~col;
   end

   AST_IDLE_READ: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_i && keys_i == '0) |=> (rd_data_o == '1)); // R4
   AST_RD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !rd_i |=> $stable(rd_data_o)); // R3
   AST_MASK_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
      !wr_i |=> $stable(mask_q)); // R5
   AST_ON_NOW: assert property (@(posedge clk) disable iff (!rst_n)
      wr_i |=> ((~mask_q & ~scan) == '0)); // R6
endmodule

// File: tb/tb_kbd_group_scan.sv
module tb_kbd_group_scan;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [63:0] keys = '0;
   logic        wr_i = 1'b0;
   logic [7:0]  wr_data = 8'hFF;
   logic        rd_i = 1'b0;
   logic [7:0]  rd_data;

   int checks = 0;
   int fails  = 0;
   bit done   = 1'b0;

   typedef struct { logic [7:0] exp; string tag; } sb_item_t;
   sb_item_t sbq[$];
   logic rd_seen = 1'b0;

   always #2.5 clk = ~clk;

   kbd_group_scan dut (
      .clk(clk), .rst_n(rst_n), .keys_i(keys), .wr_i(wr_i),
      .wr_data_i(wr_data), .rd_i(rd_i), .rd_data_o(rd_data)
   );

   function automatic logic [63:0] k(input int g, input int i);
      logic [63:0] v = '0;
      v[g*8+i] = 1'b1;
      return v;
   endfunction

   // driver tasks: each starts and ends just after a falling edge
   task automatic wr(input logic [7:0] d);
      wr_i = 1'b1; wr_data = d;
      @(negedge clk);
      wr_i = 1'b0;
   endtask

   task automatic rd(input logic [7:0] e, input string tag);
      sb_item_t it;
      it.exp = e; it.tag = tag;
      sbq.push_back(it);
      rd_i = 1'b1;
      @(negedge clk);
      rd_i = 1'b0;
   endtask

   task automatic idle(input int n);
      repeat (n) @(negedge clk);
   endtask

   // monitor
   always @(posedge clk) rd_seen <= rd_i;
   always @(negedge clk) begin
      if (rd_seen) begin
         sb_item_t it;
         checks++;
         if (sbq.size() == 0) begin
            fails++;
            $display("FAIL %s: unexpected read, actual=%h expected=none", "R3", rd_data);
         end else begin
            it = sbq.pop_front();
            if (rd_data !== it.exp) begin
               fails++;
               $display("FAIL %s: actual=%h expected=%h", it.tag, rd_data, it.exp);
            end
         end
      end
   end

   initial begin
      keys = k(0, 0);
      idle(4);
      rst_n = 1'b1;
      // R1: nothing scanned after reset
      rd(8'hFF, "R1");
      checks++;
      if (rd_data !== 8'hFF) begin
         fails++; $display("FAIL R1: reset value actual=%h expected=ff", rd_data);
      end
      // R4: everything enabled, nothing pressed
      keys = '0;
      wr(8'h00);
      rd(8'hFF, "R4");
      wr(8'hFF);
      idle(60);

      // R2 / R6: enable group 2 from all-off
      keys = k(2, 3) | k(5, 6);
      wr(8'hFB);
      rd(8'hF7, "R6 R2");
      wr(8'hDB);
      rd(8'hB7, "R2");
      // R5: value kept over a long idle
      idle(100);
      rd(8'hB7, "R5");
      // R7 / R8: two groups off, window 13
      wr(8'hFF);
      idle(12);
      rd(8'hB7, "R7 k=2 last cycle");
      rd(8'hFF, "R8 k=2 expired");
      idle(60);

      // R7: one group off, window 8
      keys = k(0, 1);
      wr(8'hFE);
      rd(8'hFD, "R6");
      wr(8'hFF);
      idle(7);
      rd(8'hFD, "R7 k=1 last cycle");
      rd(8'hFF, "R7 k=1 expired");
      idle(60);

      // R8: whole matrix off, window 48
      keys = k(7, 0);
      wr(8'h00);
      wr(8'hFF);
      idle(47);
      rd(8'hFE, "R8 k=8 last cycle");
      rd(8'hFF, "R8 k=8 expired");
      idle(60);

      // R9: re-enable and re-disable restarts the window
      keys = k(1, 2);
      wr(8'hFD);
      wr(8'hFF);
      idle(4);
      wr(8'hFD);
      wr(8'hFF);
      idle(7);
      rd(8'hFB, "R9 restarted window");
      rd(8'hFF, "R9 restarted window end");
      idle(60);
      // R9: redundant 0xFF write does not restart
      wr(8'hFD);
      wr(8'hFF);
      wr(8'hFF);
      idle(6);
      rd(8'hFB, "R9 no restart last cycle");
      rd(8'hFF, "R9 no restart expired");
      idle(60);

      // R10: bridging, direct and transitive
      keys = k(4, 1) | k(3, 1) | k(3, 5);
      wr(8'hEF);
      rd(8'hDD, "R10 direct");
      keys = keys | k(6, 5) | k(6, 7);
      rd(8'h5D, "R10 chain");
      keys = keys | k(0, 2);
      rd(8'h5D, "R10 unrelated group");
      keys = k(3, 1) | k(3, 5);
      rd(8'hFF, "R10 no bridge without scanned key");

      idle(4);
      checks++;
      if (sbq.size() != 0) begin
         fails++; $display("FAIL R3: pending reads actual=%0d expected=0", sbq.size());
      end
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         checks++; fails++;
         $display("FAIL R3: watchdog actual=timeout expected=finish");
         $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
         $finish;
      end
   end
endmodule